// File: doc/BRIEF.md
# NAND Flash Controller Register Control and Status Unit

This block is the software-facing control and status unit of a NAND flash controller. It holds a 32-bit control word and a 13-bit event status word. It also drives one level-sensitive interrupt line. Software starts a command by setting the run bit. The block answers by raising its command-word request flag. Software then writes three command words in a row to a single port address, and those words are handed to the command sequencer as one set.

Event pulses from the sequencer and the ECC logic set latched status bits. Software clears those bits by writing ones to them. Each interrupt source can be suppressed by its own mask bit, where a set bit disables the source. The run bit clears itself when a command-done event arrives, and software can also clear it to stop the command. The flash pin timing, the data FIFO and the ECC arithmetic live outside this block.

Top module: `nfc_ctl_stat`

## Requirements
- R1: After reset, the control word, the status word and the overflow flag read 0, `irq` is low and `seq_start` is low.
- R2: A pulse on `ev_pulse[k]` sets status bit k at the next clock edge. The bit positions are fixed:
  - 12: chip-select-1 ready
  - 11: chip-select-0 flash ready
  - 10 and 9: page done for CS0 and CS1
  - 8 and 7: command done for CS0 and CS1
  - 6 and 5: bad block for CS0 and CS1
  - 4: double-bit error
  - 3: single-bit error
  - 2: write-data request
  - 1: read-data request
  - 0: write-command request
- R3: A write to address 1 clears every status bit whose write-data bit is 1 (0x1FFF clears all 13 bits). If an event pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R4: `irq` is the OR over bits 11:0 of (status bit AND NOT control bit) at the same position. Status bit 12 never raises `irq`.
- R5: A control write (address 0) that sets bit 28 (run) while run is 0 sets status bit 0.
- R6: A write to the command port (address 2) while run is 0 is ignored. It stores no word and does not advance the word count.
- R7: While run is 1, three command-port writes fill words 0, 1 and 2 in that order. `seq_start` rises after the third write and stays high until `seq_take` is pulsed.
- R8: A command-port write while `seq_start` is high is ignored and sets a sticky overflow flag. The flag is read at address 3 bit 0 and cleared by writing 1 to that bit.
- R9: An event pulse on bit 8 or bit 7 clears run at the next edge. A control write of 0 to bit 28 also clears run. Whenever run is 0, a pending word set is dropped and the word count restarts at word 0.
- R10: All 32 control bits read back at address 0 as written, except bit 28, which follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 command port, 3 overflow flag |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `bus_addr` (combinational) |
| ev_pulse | input | 13 | Event pulses, one per status bit |
| seq_take | input | 1 | Sequencer has consumed the pending word set |
| seq_start | output | 1 | A complete command word set is pending |
| seq_word0 | output | 32 | Command word 0 |
| seq_word1 | output | 32 | Command word 1 |
| seq_word2 | output | 32 | Command word 2 |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are the ones where two things happen at once:
- a clear and an event landing on the same status bit in one cycle;
- a fourth command word arriving while a set is still waiting for the sequencer;
- a stop that lands partway through the three-word sequence.

Directed steps produce each of these on purpose. A later stop-and-restart checks that the words after the restart land back in word 0. A long random phase then mixes sparse events, writes to all four addresses and sequencer takes. During that phase a behavioural model is compared against the outputs on every clock.

// File: rtl/nfc_ctl_stat.sv
module nfc_ctl_stat #(
  parameter int DW      = 32,
  parameter int SW      = 13,
  parameter int RUN_BIT = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_data,
  input  logic [SW-1:0] ev_pulse,
  input  logic          seq_take,
  output logic          seq_start,
  output logic [DW-1:0] seq_word0,
  output logic [DW-1:0] seq_word1,
  output logic [DW-1:0] seq_word2,
  output logic          irq
);
  localparam int MW = SW - 1;

  logic [DW-1:0] ctrl;
  logic [SW-1:0] stat;
  logic [1:0]    idx;
  logic          pend, ovf;

  wire run     = ctrl[RUN_BIT];
  wire wr_ctrl = bus_wr && bus_addr == 2'd0;
  wire wr_stat = bus_wr && bus_addr == 2'd1;
  wire wr_cmd  = bus_wr && bus_addr == 2'd2;
  wire wr_ovf  = bus_wr && bus_addr == 2'd3;
  wire done_ev = ev_pulse[8] | ev_pulse[7];
  wire req_set = wr_ctrl && bus_wdata[RUN_BIT] && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      stat <= '0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata;
      if (done_ev) ctrl[RUN_BIT] <= 1'b0;
      stat <= (stat & ~(wr_stat ? bus_wdata[SW-1:0] : '0)) | ev_pulse
              | {{(SW-1){1'b0}}, req_set};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; pend <= 1'b0; ovf <= 1'b0;
      seq_word0 <= '0; seq_word1 <= '0; seq_word2 <= '0;
    end else begin
      if (wr_ovf && bus_wdata[0]) ovf <= 1'b0;
      if (!run) begin
        idx  <= '0;
        pend <= 1'b0;
      end else begin
        if (seq_take) pend <= 1'b0;
        if (wr_cmd) begin
          if (pend) ovf <= 1'b1;
          else begin
            case (idx)
              2'd0:    seq_word0 <= bus_wdata;
              2'd1:    seq_word1 <= bus_wdata;
              default: seq_word2 <= bus_wdata;
            endcase
            if (idx == 2'd2) begin
              idx  <= '0;
              pend <= 1'b1;
            end else idx <= idx + 2'd1;
          end
        end
      end
    end
  end

  assign seq_start = pend;
  assign irq = |(stat[MW-1:0] & ~ctrl[MW-1:0]);

  always_comb begin
    case (bus_addr)
      2'd0:    rd_data = ctrl;
      2'd1:    rd_data = {{(DW-SW){1'b0}}, stat};
      2'd3:    rd_data = {{(DW-1){1'b0}}, ovf};
      default: rd_data = '0;
    endcase
  end

  a_r9_done_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !ctrl[RUN_BIT]);
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse != '0) |=> ((stat & $past(ev_pulse)) == $past(ev_pulse)));
  a_r8_overflow_keeps_words: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && run && wr_cmd) |=> (ovf && $stable(seq_word0) && $stable(seq_word1) && $stable(seq_word2)));
  a_r6_idle_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !seq_start);
  a_r4_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[MW-1:0] == '0) |-> !irq);
  a_r5_run_raises_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_set |=> stat[0]);
endmodule

// File: tb/tb_nfc_ctl_stat.sv
module tb_nfc_ctl_stat;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, bus_wr = 0, seq_take = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [12:0] ev_pulse = 0;
  logic [31:0] rd_data, seq_word0, seq_word1, seq_word2;
  logic        seq_start, irq;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;

  logic [31:0] m_ctrl, m_w0, m_w1, m_w2;
  logic [12:0] m_stat;
  int          m_idx;
  bit          m_pend, m_err;

  nfc_ctl_stat dut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_stat = 0; m_idx = 0; m_pend = 0; m_err = 0;
      m_w0 = 0; m_w1 = 0; m_w2 = 0;
    end else begin
      bit run, wc;
      logic [31:0] nctrl;
      logic [12:0] clr;
      run = m_ctrl[28];
      wc  = bus_wr && bus_addr == 2;
      nctrl = (bus_wr && bus_addr == 0) ? bus_wdata : m_ctrl;
      if (ev_pulse[8] || ev_pulse[7]) nctrl[28] = 0;
      clr = (bus_wr && bus_addr == 1) ? bus_wdata[12:0] : 13'h0;
      m_stat = (m_stat & ~clr) | ev_pulse;
      if (bus_wr && bus_addr == 0 && bus_wdata[28] && !run) m_stat[0] = 1;
      if (bus_wr && bus_addr == 3 && bus_wdata[0]) m_err = 0;
      if (!run) begin
        m_idx = 0; m_pend = 0;
      end else begin
        bit was_pend;
        was_pend = m_pend;
        if (seq_take) m_pend = 0;
        if (wc) begin
          if (was_pend) m_err = 1;
          else begin
            if (m_idx == 0) m_w0 = bus_wdata;
            else if (m_idx == 1) m_w1 = bus_wdata;
            else m_w2 = bus_wdata;
            if (m_idx == 2) begin m_idx = 0; m_pend = 1; end
            else m_idx++;
          end
        end
      end
      m_ctrl = nctrl;
    end
  end

  always @(negedge clk) if (cmp_on && rst_n) begin
    logic [31:0] er;
    case (bus_addr)
      0: er = m_ctrl;
      1: er = {19'h0, m_stat};
      3: er = {31'h0, m_err};
      default: er = 0;
    endcase
    chk(rd_data, er, bus_addr == 0 ? "R10" : bus_addr == 1 ? "R2" : "R8");
    chk({31'h0, irq}, {31'h0, |(m_stat[11:0] & ~m_ctrl[11:0])}, "R4");
    chk({31'h0, seq_start}, {31'h0, m_pend}, "R7");
    if (m_pend) begin
      chk(seq_word0, m_w0, "R7");
      chk(seq_word1, m_w1, "R7");
      chk(seq_word2, m_w2, "R7");
    end
  end

  task automatic cyc(input bit w, input logic [1:0] a, input logic [31:0] d,
                     input logic [12:0] ev = 0, input bit tk = 0);
    @(posedge clk); #1;
    bus_wr = w; bus_addr = a; bus_wdata = d; ev_pulse = ev; seq_take = tk;
  endtask

  task automatic rd(input logic [1:0] a);
    cyc(0, a, 0);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    rd(0); chk(rd_data, 0, "R1");
    rd(1); chk(rd_data, 0, "R1");
    rd(3); chk(rd_data, 0, "R1");
    chk({31'h0, irq}, 0, "R1");
    chk({31'h0, seq_start}, 0, "R1");
    // R10 control fields, all masks set
    cyc(1, 0, 32'hE507_4FFF);
    rd(0); chk(rd_data, 32'hE507_4FFF, "R10");
    // R2 events latch
    cyc(0, 1, 0, 13'h1ABC);
    rd(1); chk(rd_data, 32'h1ABC, "R2");
    chk({31'h0, irq}, 0, "R4");
    // R4 unmask bit 3
    cyc(1, 0, 32'hE507_4FF7);
    rd(1); chk({31'h0, irq}, 1, "R4");
    cyc(1, 1, 32'hFFF);
    cyc(1, 0, 32'h0);
    rd(1); chk(rd_data, 32'h1000, "R3");
    chk({31'h0, irq}, 0, "R4");
    // R3 event wins over clear
    cyc(1, 1, 32'h20, 13'h0020);
    rd(1); chk(rd_data, 32'h1020, "R3");
    cyc(1, 1, 32'h1FFF);
    rd(1); chk(rd_data, 0, "R3");
    // R6 command write while idle is ignored
    cyc(1, 2, 32'h99);
    cyc(1, 0, 32'h1000_0FFF);
    rd(1); chk(rd_data, 32'h1, "R5");
    cyc(1, 2, 32'hA);
    cyc(1, 2, 32'hB);
    rd(0); chk({31'h0, seq_start}, 0, "R6");
    cyc(1, 2, 32'hC);
    rd(0); chk({31'h0, seq_start}, 1, "R7");
    chk(seq_word0, 32'hA, "R7");
    chk(seq_word1, 32'hB, "R7");
    chk(seq_word2, 32'hC, "R7");
    // R8 overflow
    cyc(1, 2, 32'hD);
    rd(3); chk(rd_data, 1, "R8");
    chk(seq_word0, 32'hA, "R8");
    chk(seq_word2, 32'hC, "R8");
    cyc(1, 3, 32'h1);
    rd(3); chk(rd_data, 0, "R8");
    cyc(0, 0, 0, 0, 1);
    rd(0); chk({31'h0, seq_start}, 0, "R7");
    // R9 done event clears run
    cyc(0, 0, 0, 13'h0100);
    rd(0); chk(rd_data, 32'h0000_0FFF, "R9");
    // R9 software stop mid-sequence, then restart
    cyc(1, 0, 32'h1000_0FFF);
    cyc(1, 2, 32'h77);
    cyc(1, 0, 32'h0000_0FFF);
    cyc(1, 0, 32'h1000_0FFF);
    cyc(1, 2, 32'h1);
    cyc(1, 2, 32'h2);
    cyc(1, 2, 32'h3);
    rd(0); chk({31'h0, seq_start}, 1, "R9");
    chk(seq_word0, 32'h1, "R9");
    chk(seq_word2, 32'h3, "R9");
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic [12:0] ev;
      logic [31:0] d;
      ev = 0;
      for (int b = 0; b < 13; b++) if ($urandom_range(0, 19) == 0) ev[b] = 1;
      if ($urandom_range(0, 3) != 0) ev[8:7] = 0;
      d = $urandom;
      if ($urandom_range(0, 1) == 0) d[28] = 1;
      cyc($urandom_range(0, 2) != 0, 2'($urandom_range(0, 3)), d, ev,
          $urandom_range(0, 5) == 0);
    end
    rd(1);
    finish_run();
  end
endmodule